// File: doc/BRIEF.md
# Memory Field Select Arbiter

This block decides, once per memory cycle, which memory field the cycle addresses, and drives one active-high enable per field to the memory timing generators. It picks from three field values: the current instruction field, the current data field, and a break field that it captures itself from an external device line one cycle before a data break begins.

The choice depends on the kind of cycle. A data-break cycle always uses the captured break field. A console load-address operation with the instruction-field switch uses the instruction field. The operand cycle of an indirectly addressed data instruction (AND, TAD, ISZ, DCA) uses the data field. Every other cycle, including the indirect operand cycles of JMP and JMS, uses the instruction field. The chosen value is registered into an extended-address register at a start-of-cycle strobe and held there for the whole cycle. The field enables are decoded from that register.

Top module: `mem_field_sel`

## Requirements
- R1: After reset the extended-address output is 0, only the field 0 enable is high, and the break field register holds 0.
- R2: Exactly one field enable is high at any time, and it is the enable whose index equals the extended-address output (field 0 enable = inverse of the extended address, field 1 enable = the extended address, for two fields).
- R3: The extended-address register changes only at a rising clock edge where `cycle_strobe_i` is high. Between strobes it holds its value, whatever the field inputs do.
- R4: At a strobe with no break cycle, no console load and no indirect data reference, the extended address takes `if_i`. This covers cycles outside an indirect operand cycle and opcodes 6 and 7.
- R5: At a strobe with `defer_cycle_i` high and `opcode_i` in 0..3 (AND=0, TAD=1, ISZ=2, DCA=3), and with no break cycle and no console load, the extended address takes `df_i`.
- R6: At a strobe with `defer_cycle_i` high and `opcode_i` equal to 4 (JMS) or 5 (JMP), and with no break cycle and no console load, the extended address takes `if_i`.
- R7: At a strobe with `brk_cycle_i` high, the extended address takes the break field register, whatever the other select inputs are.
- R8: The break field register loads `ext_addr_i` at a rising edge where `brk_load_i` is high and holds its value at every other edge.
- R9: At a strobe with `console_load_i` high and no break cycle, the extended address takes `if_i`, even during an indirect data reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_i | input | FW | Current instruction field |
| df_i | input | FW | Current data field |
| ext_addr_i | input | FW | Extended data address line from the break device |
| brk_load_i | input | 1 | Timing pulse of the cycle before a break; captures `ext_addr_i` |
| brk_cycle_i | input | 1 | The cycle being started is a data-break cycle |
| defer_cycle_i | input | 1 | The cycle being started is an indirect operand cycle |
| opcode_i | input | 3 | Top three bits of the current instruction |
| console_load_i | input | 1 | Console load-address with the instruction-field switch |
| cycle_strobe_i | input | 1 | Start-of-cycle strobe; updates the extended address |
| ea_o | output | FW | Registered extended-address field |
| field_en_o | output | NUM_FIELDS | One active-high enable per memory field |

## Verification
A wrong priority or a wrong decode in the source select shows up at `ea_o` and at the field enables in the cycle right after the strobe edge. The bench sweeps every combination of field values, cycle type, opcode and console state, so each such fault appears in at least one combination. A break field register that loads at the wrong time or keeps a stale value shows up the next time a break cycle is strobed; the bench moves the device line after each capture to catch this. A register that follows its inputs between strobes shows up as a change of `ea_o` in the cycle after the field inputs are toggled with no strobe.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0,
    OP_TAD = 3'd1,
    OP_ISZ = 3'd2,
    OP_DCA = 3'd3,
    OP_JMS = 3'd4,
    OP_JMP = 3'd5,
    OP_IOT = 3'd6,
    OP_OPR = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    SRC_IF = 2'd0,
    SRC_DF = 2'd1,
    SRC_BF = 2'd2
  } src_e;

  // True for memory-reference instructions that fetch a data operand
  function automatic logic is_data_ref(input logic [OP_W-1:0] op);
    case (opcode_e'(op))
      OP_AND, OP_TAD, OP_ISZ, OP_DCA: is_data_ref = 1'b1;
      default:                        is_data_ref = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mfs_brk_reg.sv
module mfs_brk_reg #(
  parameter int unsigned FW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [FW-1:0] d_i,
  output logic [FW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/mfs_src_sel.sv
module mfs_src_sel
  import mfs_pkg::*;
#(
  parameter int unsigned FW = 1
) (
  input  logic [FW-1:0]   if_i,
  input  logic [FW-1:0]   df_i,
  input  logic [FW-1:0]   bf_i,
  input  logic            brk_cycle_i,
  input  logic            defer_cycle_i,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            console_load_i,
  output src_e            src_o,
  output logic [FW-1:0]   field_o
);
  // Priority: break, console load, indirect data operand, instruction field
  always_comb begin
    if (brk_cycle_i)                              src_o = SRC_BF;
    else if (console_load_i)                      src_o = SRC_IF;
    else if (defer_cycle_i && is_data_ref(opcode_i)) src_o = SRC_DF;
    else                                          src_o = SRC_IF;
  end

  always_comb begin
    case (src_o)
      SRC_BF:  field_o = bf_i;
      SRC_DF:  field_o = df_i;
      default: field_o = if_i;
    endcase
  end
endmodule

// File: rtl/mfs_ea_reg.sv
module mfs_ea_reg #(
  parameter int unsigned NUM_FIELDS = 2,
  parameter int unsigned FW         = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  strobe_i,
  input  logic [FW-1:0]         d_i,
  output logic [FW-1:0]         ea_o,
  output logic [NUM_FIELDS-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ea_o <= '0;
    else if (strobe_i) ea_o <= d_i;
  end

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_en
    assign en_o[k] = (ea_o == FW'(k));
  end
endmodule

// File: rtl/mem_field_sel.sv
module mem_field_sel
  import mfs_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 2,
  localparam int unsigned FW = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [FW-1:0]         if_i,
  input  logic [FW-1:0]         df_i,
  input  logic [FW-1:0]         ext_addr_i,
  input  logic                  brk_load_i,
  input  logic                  brk_cycle_i,
  input  logic                  defer_cycle_i,
  input  logic [OP_W-1:0]       opcode_i,
  input  logic                  console_load_i,
  input  logic                  cycle_strobe_i,
  output logic [FW-1:0]         ea_o,
  output logic [NUM_FIELDS-1:0] field_en_o
);
  logic [FW-1:0] bf_q;
  logic [FW-1:0] next_field;
  src_e          src;

  mfs_brk_reg #(.FW(FW)) u_brk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (brk_load_i),
    .d_i    (ext_addr_i),
    .q_o    (bf_q)
  );

  mfs_src_sel #(.FW(FW)) u_sel (
    .if_i           (if_i),
    .df_i           (df_i),
    .bf_i           (bf_q),
    .brk_cycle_i    (brk_cycle_i),
    .defer_cycle_i  (defer_cycle_i),
    .opcode_i       (opcode_i),
    .console_load_i (console_load_i),
    .src_o          (src),
    .field_o        (next_field)
  );

  mfs_ea_reg #(.NUM_FIELDS(NUM_FIELDS), .FW(FW)) u_ea (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (cycle_strobe_i),
    .d_i      (next_field),
    .ea_o     (ea_o),
    .en_o     (field_en_o)
  );
endmodule

// File: rtl/mem_field_sel_chk.sv
module mem_field_sel_chk #(
  parameter int unsigned NUM_FIELDS = 2,
  parameter int unsigned FW = 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [FW-1:0]         if_i,
  input logic [FW-1:0]         df_i,
  input logic [FW-1:0]         ext_addr_i,
  input logic                  brk_load_i,
  input logic                  brk_cycle_i,
  input logic                  defer_cycle_i,
  input logic [2:0]            opcode_i,
  input logic                  console_load_i,
  input logic                  cycle_strobe_i,
  input logic [FW-1:0]         ea_o,
  input logic [NUM_FIELDS-1:0] field_en_o,
  input logic [FW-1:0]         bf_q
);
  logic data_ref;
  assign data_ref = defer_cycle_i && (opcode_i < 3'd4);

  assert_one_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(field_en_o) == 1) && field_en_o[ea_o]);

  assert_hold_between_strobes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_strobe_i |=> $stable(ea_o));

  assert_default_if_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_strobe_i && !brk_cycle_i && !console_load_i && !defer_cycle_i |=> ea_o == $past(if_i));

  assert_indirect_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_strobe_i && !brk_cycle_i && !console_load_i && data_ref |=> ea_o == $past(df_i));

  assert_indirect_jump_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_strobe_i && !brk_cycle_i && !console_load_i && defer_cycle_i &&
    (opcode_i == 3'd4 || opcode_i == 3'd5) |=> ea_o == $past(if_i));

  assert_break_field_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_strobe_i && brk_cycle_i |=> ea_o == $past(bf_q));

  assert_bf_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_load_i |=> bf_q == $past(ext_addr_i));

  assert_bf_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brk_load_i |=> $stable(bf_q));

  assert_console_if_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_strobe_i && !brk_cycle_i && console_load_i |=> ea_o == $past(if_i));
endmodule

bind mem_field_sel mem_field_sel_chk #(.NUM_FIELDS(NUM_FIELDS), .FW(FW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .if_i           (if_i),
  .df_i           (df_i),
  .ext_addr_i     (ext_addr_i),
  .brk_load_i     (brk_load_i),
  .brk_cycle_i    (brk_cycle_i),
  .defer_cycle_i  (defer_cycle_i),
  .opcode_i       (opcode_i),
  .console_load_i (console_load_i),
  .cycle_strobe_i (cycle_strobe_i),
  .ea_o           (ea_o),
  .field_en_o     (field_en_o),
  .bf_q           (bf_q)
);

// File: tb/sim_mem_field_sel.sv
`timescale 1ns/1ps
module sim_mem_field_sel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       if_i = 1'b0, df_i = 1'b0, ext_addr_i = 1'b0;
  logic       brk_load_i = 1'b0, brk_cycle_i = 1'b0, defer_cycle_i = 1'b0;
  logic [2:0] opcode_i = 3'd0;
  logic       console_load_i = 1'b0, cycle_strobe_i = 1'b0;
  logic       ea_o;
  logic [1:0] field_en_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  mem_field_sel u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string rule_tag(input logic brk, input logic con,
                                     input logic dfr, input logic [2:0] op);
    if (brk)                   return "R7";
    if (con)                   return "R9";
    if (dfr && op < 3'd4)      return "R5";
    if (dfr && op < 3'd6)      return "R6";
    return "R4";
  endfunction

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    check("R1 ea", int'(ea_o), 0);
    check("R1 en", int'(field_en_o), 1);
    // R1: break field reset to 0, seen through a break cycle
    if_i = 1'b1; df_i = 1'b1; brk_cycle_i = 1'b1; cycle_strobe_i = 1'b1;
    @(negedge clk_i);
    cycle_strobe_i = 1'b0; brk_cycle_i = 1'b0;
    check("R1 bf", int'(ea_o), 0);

    for (int v = 0; v < 512; v++) begin
      logic iv, dv, ev, brk, con, dfr, expv;
      logic [2:0] op;
      string tag;
      iv = v[0]; dv = v[1]; ev = v[2]; brk = v[3]; con = v[4]; dfr = v[5];
      op = v[8:6];
      // capture break field, then move the device line away
      ext_addr_i = ev; brk_load_i = 1'b1;
      @(negedge clk_i);
      brk_load_i = 1'b0; ext_addr_i = ~ev;
      if_i = iv; df_i = dv; brk_cycle_i = brk; console_load_i = con;
      defer_cycle_i = dfr; opcode_i = op; cycle_strobe_i = 1'b1;
      @(negedge clk_i);
      cycle_strobe_i = 1'b0;
      if (brk)                    expv = ev;
      else if (con)               expv = iv;
      else if (dfr && op < 3'd4)  expv = dv;
      else                        expv = iv;
      tag = rule_tag(brk, con, dfr, op);
      if (brk) tag = "R7/R8";
      check(tag, int'(ea_o), int'(expv));
      // R2: enable decode
      check("R2", int'(field_en_o), expv ? 2 : 1);
      // R3: inputs flip with no strobe, output must hold
      if_i = ~iv; df_i = ~dv; brk_cycle_i = ~brk; console_load_i = ~con;
      @(negedge clk_i);
      check("R3", int'(ea_o), int'(expv));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule